// File: doc/BRIEF.md
# Interrupt Flag and Enable Register

This block gathers five one-cycle event pulses from the rest of a peripheral (two timer underflows, a clock alarm, a shift register completion and an external edge detector) into latched flags, and raises an active-low, level-sensitive interrupt request whenever a latched flag belongs to an enabled source. Flags latch every event, whether the source is enabled or not. The enables only decide whether the request line is driven.

Software reaches the block through one 8-bit location on a simple synchronous bus. A write changes only the enable bits named by ones in the low five data bits. The top data bit selects whether those enables are turned on or off, so one source can be changed without knowing the state of the others. A read returns the flags plus a summary bit, and the same read acknowledges them. All flags drop and the request is released, except for an event that arrives in the very cycle of the read. That event is kept.

Top module: `irq_ctl_reg`

## Requirements
- R1: Each event input sets its own flag bit: timer A bit 0, timer B bit 1, alarm bit 2, shift register bit 3, edge input bit 4, and the flag stays set until a read.
- R2: Flags latch events whatever the enable bits are, and more events only add flags.
- R3: A write with data bit 7 = 1 turns on every enable whose data bit in 0–4 is 1.
- R4: A write with data bit 7 = 0 turns off every enable whose data bit in 0–4 is 1.
- R5: Enables whose data bit is 0 keep their value on any write, and data bits 5–6 have no effect.
- R6: Read data, valid in the cycle the read is presented, carries the flags in bits 0–4, zeros in bits 5–6, and in bit 7 a 1 exactly when some flag has its enable on.
- R7: The clock edge that ends a read clears all flags, and with them the summary bit, so irq_n returns high.
- R8: irq_n is low for every cycle in which any flag with its enable on is pending, and stays low until that flag is acknowledged or its enable is turned off.
- R9: An event arriving in the same cycle as a read is not cleared: it is absent from that read's data and present on the next read.
- R10: After reset all enables and flags are 0 and irq_n is 1.
- R11: When a write turns on the enable of a source whose flag is already pending, irq_n goes low right after that write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_a_evt | input | 1 | Timer A underflow pulse |
| tmr_b_evt | input | 1 | Timer B underflow pulse |
| alarm_evt | input | 1 | Clock alarm pulse |
| shift_evt | input | 1 | Shift register complete pulse |
| edge_evt | input | 1 | External edge detected pulse |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| irq_n | output | 1 | Level-sensitive interrupt request, active low |

## Verification
A read that acknowledges the flags can coincide with a new event pulse, and the clear must not swallow it. The bench latches one pattern, then presents a read together with a second pattern for every pair of five-bit patterns. It expects only the first pattern in that read's data and only the second in the following read. Enable writes are swept over every prior enable state, data pattern and mode, and each enable bit is probed separately through irq_n after a single-source event.

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_a_evt,
  input  logic              tmr_b_evt,
  input  logic              alarm_evt,
  input  logic              shift_evt,
  input  logic              edge_evt,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n
);
  localparam int MODE_BIT = DATA_W - 1;

  logic [NUM_SRC-1:0] evt_vec, flag_q, mask_q, src_bits;
  logic rd_acc, wr_acc, pending_any;
  logic unused_pad;

  assign evt_vec     = {edge_evt, shift_evt, alarm_evt, tmr_b_evt, tmr_a_evt};
  assign rd_acc      = bus_sel & ~bus_wr;
  assign wr_acc      = bus_sel & bus_wr;
  assign src_bits    = bus_wdata[NUM_SRC-1:0];
  assign pending_any = |(flag_q & mask_q);
  assign irq_n       = ~pending_any;
  assign unused_pad  = ^bus_wdata[MODE_BIT-1:NUM_SRC];

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= '0;
    else if (rd_acc) flag_q <= evt_vec;
    else             flag_q <= flag_q | evt_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_acc) begin
      if (bus_wdata[MODE_BIT]) mask_q <= mask_q | src_bits;
      else                     mask_q <= mask_q & ~src_bits;
    end
  end

  always_comb begin
    bus_rdata                = '0;
    bus_rdata[NUM_SRC-1:0]   = flag_q;
    bus_rdata[MODE_BIT]      = pending_any;
  end
endmodule

module irq_ctl_reg_chk #(
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_n,
  input logic [NUM_SRC-1:0] evt,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] mask
);
  localparam int MB = DATA_W - 1;

  a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));
  a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_wdata[MB]) |=>
      ((mask & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_wdata[MB]) |=>
      ((mask & $past(bus_wdata[NUM_SRC-1:0])) == '0));
  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask & ~$past(bus_wdata[NUM_SRC-1:0])) ==
              ($past(mask) & ~$past(bus_wdata[NUM_SRC-1:0]))));
  a_r6_pad: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[MB-1:NUM_SRC] == '0);
  a_r8_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !(bus_sel && !bus_wr) && !(bus_sel && bus_wr && !bus_wdata[MB])) |=> !irq_n);
  a_r9_keep_new: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> (flags == $past(evt)));
  a_r10_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_n && flags == '0 && mask == '0));
  a_r11_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_wdata[MB] && |(bus_wdata[NUM_SRC-1:0] & flags)) |=> !irq_n);
endmodule

bind irq_ctl_reg irq_ctl_reg_chk #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n),
  .evt(evt_vec), .flags(flag_q), .mask(mask_q)
);

// File: tb/test_irq_ctl_reg.sv
module test_irq_ctl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] ev = '0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;
  int checks = 0, errors = 0;
  logic [7:0] r;

  always #2.5 clk = ~clk;

  irq_ctl_reg i_irq_ctl_reg (
    .clk(clk), .rst_n(rst_n),
    .tmr_a_evt(ev[0]), .tmr_b_evt(ev[1]), .alarm_evt(ev[2]),
    .shift_evt(ev[3]), .edge_evt(ev[4]),
    .bus_sel(sel), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; wdata = d;
    @(negedge clk); sel = 0; wr = 0; wdata = '0;
  endtask

  task automatic do_rd(input logic [4:0] e, output logic [7:0] q);
    @(negedge clk); sel = 1; wr = 0; ev = e;
    #1 q = rdata;
    @(negedge clk); sel = 0; ev = '0;
  endtask

  task automatic pulse(input logic [4:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  task automatic set_mask(input logic [4:0] m);
    do_wr(8'h1F);
    do_wr({1'b1, 2'b00, m});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq_n", {7'd0, irq_n}, 8'd1);
    chk("R10 rdata", rdata, 8'h00);
    pulse(5'h1F);
    chk("R10 mask zero", {7'd0, irq_n}, 8'd1);
    do_rd(5'h0, r);
    chk("R10 flags", r, 8'h1F);

    // R1 bit positions, R2 latch while disabled
    for (int b = 0; b < 5; b++) begin
      pulse(5'(1 << b));
      chk("R2 disabled irq_n", {7'd0, irq_n}, 8'd1);
      do_rd(5'h0, r);
      chk("R1 bit map", r, 8'(1 << b));
    end

    // R6 R7 R8 sweep of enables x flags
    for (int m = 0; m < 32; m++) begin
      for (int f = 0; f < 32; f++) begin
        logic hit;
        hit = |(5'(m) & 5'(f));
        set_mask(5'(m));
        do_rd(5'h0, r);
        pulse(5'(f));
        chk("R8 irq_n", {7'd0, irq_n}, {7'd0, ~hit});
        @(negedge clk);
        chk("R8 held", {7'd0, irq_n}, {7'd0, ~hit});
        if (f != 0) begin
          pulse(5'(f & 5'h15));
          chk("R2 accumulate", {3'd0, 5'(f)}, {3'd0, rdata[4:0]});
        end
        do_rd(5'h0, r);
        chk("R6 rdata", r, {hit, 2'b00, 5'(f)});
        chk("R7 release", {7'd0, irq_n}, 8'd1);
        do_rd(5'h0, r);
        chk("R7 cleared", r, 8'h00);
      end
    end

    // R3 R4 R5 set/clear writes, each enable probed alone
    for (int m0 = 0; m0 < 32; m0++) begin
      for (int c = 0; c < 32; c++) begin
        for (int md = 0; md < 2; md++) begin
          logic [4:0] em;
          em = md[0] ? (5'(m0) | 5'(c)) : (5'(m0) & ~5'(c));
          set_mask(5'(m0));
          do_wr({md[0], 2'b11, 5'(c)});
          for (int b = 0; b < 5; b++) begin
            pulse(5'(1 << b));
            chk(md[0] ? "R3 R5 set" : "R4 R5 clear", {7'd0, irq_n}, {7'd0, ~em[b]});
            do_rd(5'h0, r);
          end
        end
      end
    end

    // R9 event coinciding with the acknowledging read
    set_mask(5'h1F);
    for (int f1 = 0; f1 < 32; f1++) begin
      for (int f2 = 0; f2 < 32; f2++) begin
        pulse(5'(f1));
        do_rd(5'(f2), r);
        chk("R9 first read", r, {(f1 != 0), 2'b00, 5'(f1)});
        do_rd(5'h0, r);
        chk("R9 kept", r, {(f2 != 0), 2'b00, 5'(f2)});
      end
    end

    // R11 enabling an already pending source
    for (int b = 0; b < 5; b++) begin
      set_mask(5'h0);
      do_rd(5'h0, r);
      pulse(5'(1 << b));
      chk("R11 before", {7'd0, irq_n}, 8'd1);
      @(negedge clk); sel = 1; wr = 1; wdata = 8'(8'h80 | (1 << b));
      @(negedge clk); sel = 0; wr = 0; wdata = '0;
      chk("R11 after", {7'd0, irq_n}, 8'd0);
      do_rd(5'h0, r);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule